// File: doc/BRIEF.md
# Radio Register SPI Transaction Engine

This block is an SPI master that carries out one complete register transaction with a 2.4 GHz packet radio for each accepted request. A request names a command byte, a direction (write or read) and a burst length of 0 to 32 data bytes. The engine lowers chip select, shifts out the command byte, and then shifts the burst: write bytes are pulled one at a time from a valid/ready byte stream, and read bytes are produced by sending 0x00 filler while the device answers. It then raises chip select again.

The byte that the radio returns while the command is being shifted is the device status. The engine keeps it and presents it on a status output when the transaction finishes, along with a one-cycle completion pulse. Serial clock timing comes from a parameter that gives the number of system clock cycles in each SCK half-period. The same count sets the chip-select setup, hold and idle gaps, so a single value meets the device's minimum timing at the chosen system clock.

Top module: `radio_spi_engine`

## Requirements
- R1: After reset, csn_o is high, sck_o is low, busy_o is low and req_ready_o is high.
- R2: The command byte is the first byte of every frame and is sent unchanged, most significant bit first. mosi_o changes only while sck_o is low and holds steady while sck_o is high.
- R3: miso_i is sampled at the end of each SCK high phase and shifted in from the least significant end. The byte received during the command byte appears on status_o together with done_o, and status_o changes at no other time.
- R4: In a write (req_rd_i = 0), each data byte is taken from wr_data_i on a cycle where wr_valid_i and wr_ready_o are both high, and the bytes go out in order. wr_ready_o is high only while chip select is low, SCK is low, and the engine is waiting for the next write byte.
- R5: In a read (req_rd_i = 1), every data byte sent on mosi_o is 0x00. Each received byte appears on rd_data_o with a single-cycle rd_valid_o, in order, and exactly one pulse is given per requested byte. The write stream is ignored.
- R6: A zero-length request produces a frame that holds only the command byte. It accepts no write byte and gives no rd_valid_o pulse.
- R7: csn_o stays low for the whole frame. A frame holds exactly 8 × (length + 1) SCK pulses, and sck_o is low whenever csn_o changes or is high.
- R8: Every level of sck_o and csn_o lasts at least HALF_CYC cycles. This covers CSN fall to the first SCK rise, each SCK high and low phase, the last SCK fall to CSN rise, and the CSN-high gap before the next frame.
- R9: busy_o is high from the cycle after a request is accepted until csn_o rises. done_o pulses for one cycle exactly when csn_o rises. req_ready_o is high only when busy_o is low.
- R10: A requested length above MAX_LEN (32) is treated as MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Engine idle and able to accept a request |
| req_cmd_i | input | 8 | Command byte for the frame |
| req_rd_i | input | 1 | 1 = read burst, 0 = write burst |
| req_len_i | input | 6 | Burst length in bytes, 0 to 32 |
| wr_data_i | input | 8 | Write byte stream data |
| wr_valid_i | input | 1 | Write byte offered |
| wr_ready_o | output | 1 | Engine takes the offered write byte |
| rd_data_o | output | 8 | Received burst byte |
| rd_valid_o | output | 1 | One-cycle strobe for rd_data_o |
| status_o | output | 8 | Device status captured during the command byte |
| done_o | output | 1 | One-cycle pulse when the frame ends |
| busy_o | output | 1 | Transaction in progress |
| csn_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |

## Verification
The bench sweeps every burst length from 0 to 32 in both directions, plus an over-length request. A device model on the serial pins returns a status byte and a distinct data byte for each position, and these values change from transaction to transaction. Because of this, a swapped bit order, a lost or extra byte, or a status captured from the wrong byte all show up as mismatches. Reads are run while the write stream is held valid, so an engine that wrongly pulls write data during a read or a zero-length frame is caught. Writes use position-dependent data, which exposes reordering. A level-duration monitor on SCK and chip select measures the shortest phase seen across all runs, including the gaps between back-to-back frames.

// File: rtl/radio_spi_pkg.sv
package radio_spi_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] FILL_BYTE = '0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_FETCH,
    ST_HOLD,
    ST_GAP
  } spi_state_e;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int HALF_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import radio_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_next_o
);
  logic [BYTE_W-1:0] tx_q, rx_q;

  assign mosi_o    = tx_q[BYTE_W-1];
  assign rx_next_o = {rx_q[BYTE_W-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_q <= '0;
    else if (load_i)  tx_q <= load_byte_i;
    else if (shift_i) tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (sample_i) rx_q <= rx_next_o;
  end
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import radio_spi_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BYTE_W-1:0] req_cmd_i,
  input  logic              req_rd_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic              tick_i,
  output logic              run_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] load_byte_o,
  output logic              shift_o,
  output logic              sample_o,
  input  logic [BYTE_W-1:0] rx_next_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] status_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              csn_o,
  output logic              sck_o
);
  localparam logic [LEN_W-1:0]  LEN_CAP  = LEN_W'(MAX_LEN);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BYTE_W - 1);

  spi_state_e        state_q;
  logic [BIT_W-1:0]  bit_q;
  logic [LEN_W-1:0]  left_q;
  logic              rd_q, cmd_phase_q;
  logic [BYTE_W-1:0] stat_q, stat_out_q, rd_data_q;
  logic              rd_valid_q, done_q;
  logic              bit_end, byte_end;

  assign bit_end  = (state_q == ST_HIGH) && tick_i;
  assign byte_end = bit_end && (bit_q == LAST_BIT);

  assign run_o = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HIGH) ||
                 (state_q == ST_HOLD)  || (state_q == ST_GAP);

  assign req_ready_o = (state_q == ST_IDLE);
  assign wr_ready_o  = (state_q == ST_FETCH);
  assign csn_o       = (state_q == ST_IDLE) || (state_q == ST_GAP);
  assign sck_o       = (state_q == ST_HIGH);
  assign busy_o      = !csn_o;
  assign shift_o     = bit_end && !byte_end;
  assign sample_o    = bit_end;

  always_comb begin
    load_o      = 1'b0;
    load_byte_o = FILL_BYTE;
    unique case (state_q)
      ST_IDLE: begin
        load_o      = req_valid_i;
        load_byte_o = req_cmd_i;
      end
      ST_FETCH: begin
        load_o      = wr_valid_i;
        load_byte_o = wr_data_i;
      end
      ST_HIGH: load_o = byte_end && (left_q != '0) && rd_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_q       <= '0;
      left_q      <= '0;
      rd_q        <= 1'b0;
      cmd_phase_q <= 1'b0;
      stat_q      <= '0;
      stat_out_q  <= '0;
      rd_data_q   <= '0;
      rd_valid_q  <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      done_q     <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          rd_q        <= req_rd_i;
          left_q      <= (req_len_i > LEN_CAP) ? LEN_CAP : req_len_i;
          cmd_phase_q <= 1'b1;
          state_q     <= ST_SETUP;
        end
        ST_SETUP: if (tick_i) begin
          bit_q   <= '0;
          state_q <= ST_LOW;
        end
        ST_LOW: if (tick_i) state_q <= ST_HIGH;
        ST_HIGH: if (tick_i) begin
          if (bit_q != LAST_BIT) begin
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_LOW;
          end else begin
            if (cmd_phase_q) stat_q <= rx_next_i;
            else if (rd_q) begin
              rd_data_q  <= rx_next_i;
              rd_valid_q <= 1'b1;
            end
            cmd_phase_q <= 1'b0;
            bit_q       <= '0;
            if (left_q == '0) state_q <= ST_HOLD;
            else begin
              left_q  <= left_q - 1'b1;
              state_q <= rd_q ? ST_LOW : ST_FETCH;
            end
          end
        end
        ST_FETCH: if (wr_valid_i) state_q <= ST_LOW;
        ST_HOLD: if (tick_i) begin
          stat_out_q <= stat_q;
          done_q     <= 1'b1;
          state_q    <= ST_GAP;
        end
        ST_GAP: if (tick_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
  assign status_o   = stat_out_q;
  assign done_o     = done_q;
endmodule

// File: rtl/radio_spi_engine.sv
module radio_spi_engine
  import radio_spi_pkg::*;
#(
  parameter int HALF_CYC = 6,
  parameter int MAX_LEN  = 32,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BYTE_W-1:0] req_cmd_i,
  input  logic              req_rd_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] status_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              csn_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic              run, tick, load, shift, sample;
  logic [BYTE_W-1:0] load_byte, rx_next;

  spi_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  spi_byte_shifter u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_byte_i (load_byte),
    .shift_i     (shift),
    .sample_i    (sample),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_next_o   (rx_next)
  );

  spi_frame_ctrl #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_cmd_i   (req_cmd_i),
    .req_rd_i    (req_rd_i),
    .req_len_i   (req_len_i),
    .wr_data_i   (wr_data_i),
    .wr_valid_i  (wr_valid_i),
    .wr_ready_o  (wr_ready_o),
    .tick_i      (tick),
    .run_o       (run),
    .load_o      (load),
    .load_byte_o (load_byte),
    .shift_o     (shift),
    .sample_o    (sample),
    .rx_next_i   (rx_next),
    .rd_data_o   (rd_data_o),
    .rd_valid_o  (rd_valid_o),
    .status_o    (status_o),
    .done_o      (done_o),
    .busy_o      (busy_o),
    .csn_o       (csn_o),
    .sck_o       (sck_o)
  );
endmodule

// File: rtl/radio_spi_engine_chk.sv
module radio_spi_engine_chk #(
  parameter int HALF_CYC = 6
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       csn_o,
  input logic       sck_o,
  input logic       mosi_o,
  input logic       busy_o,
  input logic       req_ready_o,
  input logic       wr_ready_o,
  input logic       rd_valid_o,
  input logic       done_o,
  input logic [7:0] status_o
);
  logic        csn_q, sck_q;
  int unsigned hold_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_q    <= 1'b1;
      sck_q    <= 1'b0;
      hold_cnt <= HALF_CYC;
    end else begin
      csn_q <= csn_o;
      sck_q <= sck_o;
      if ((csn_o != csn_q) || (sck_o != sck_q)) hold_cnt <= 1;
      else if (hold_cnt < HALF_CYC)              hold_cnt <= hold_cnt + 1;
    end
  end

  // R8
  min_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((csn_o != csn_q) || (sck_o != sck_q)) |-> (hold_cnt >= HALF_CYC));

  // R7
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_o |-> !sck_o);

  // R2
  mosi_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  // R9
  done_at_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(csn_o) |-> done_o);

  // R9
  done_only_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(csn_o));

  // R9
  busy_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csn_o |-> busy_o);

  // R9
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !busy_o);

  // R4
  wr_ready_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> (!csn_o && !sck_o));

  // R5
  rd_valid_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !csn_o);

  // R3
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(status_o));
endmodule

bind radio_spi_engine radio_spi_engine_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csn_o       (csn_o),
  .sck_o       (sck_o),
  .mosi_o      (mosi_o),
  .busy_o      (busy_o),
  .req_ready_o (req_ready_o),
  .wr_ready_o  (wr_ready_o),
  .rd_valid_o  (rd_valid_o),
  .done_o      (done_o),
  .status_o    (status_o)
);

// File: tb/radio_spi_engine_bench.sv
module radio_spi_engine_bench;
  localparam int HALF = 6;
  localparam int MAXL = 32;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0, req_rd_i = 1'b0;
  logic [7:0] req_cmd_i = '0, wr_data_i = '0;
  logic [5:0] req_len_i = '0;
  logic       wr_valid_i = 1'b0;
  logic       req_ready_o, wr_ready_o, rd_valid_o, done_o, busy_o;
  logic       csn_o, sck_o, mosi_o, miso_i;
  logic [7:0] rd_data_o, status_o;

  always #5 clk_i = ~clk_i;

  radio_spi_engine #(.HALF_CYC(HALF), .MAX_LEN(MAXL)) u_radio_spi_engine (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_cmd_i(req_cmd_i),
    .req_rd_i(req_rd_i), .req_len_i(req_len_i),
    .wr_data_i(wr_data_i), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .status_o(status_o),
    .done_o(done_o), .busy_o(busy_o),
    .csn_o(csn_o), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  int n_chk = 0, n_fail = 0, n_tx = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model
  logic [7:0] s_tx = '0, s_rx = '0, s_seed = '0, s_base = '0;
  int         s_bit = 0, s_nbytes = 0;
  logic [7:0] s_got [64];
  assign miso_i = s_tx[7];

  function automatic logic [7:0] pat(input logic [7:0] base, input int k);
    return 8'(int'(base) + k * 53);
  endfunction

  always @(negedge csn_o) begin
    s_tx = s_seed; s_bit = 0; s_nbytes = 0;
  end
  always @(posedge sck_o) begin
    s_rx = {s_rx[6:0], mosi_o};
    s_bit++;
    if (s_bit == 8) begin
      if (s_nbytes < 64) s_got[s_nbytes] = s_rx;
      s_nbytes++;
      s_bit = 0;
    end
  end
  always @(negedge sck_o) if (!csn_o) begin
    if (s_bit == 0) s_tx = pat(s_base, s_nbytes);
    else            s_tx = {s_tx[6:0], 1'b0};
  end

  // stream and timing monitors
  logic [7:0] rd_got [64];
  int rd_n = 0, wr_acc = 0, busy_err = 0;
  int run_len = 100, min_run = 1000;
  logic [1:0] lvl_q = 2'b10;
  always @(negedge clk_i) if (rst_ni) begin
    if (rd_valid_o) begin
      if (rd_n < 64) rd_got[rd_n] = rd_data_o;
      rd_n++;
    end
    if (wr_valid_i && wr_ready_o) wr_acc++;
    if (!csn_o && !busy_o) busy_err++;
    if ({csn_o, sck_o} != lvl_q) begin
      if (run_len < min_run) min_run = run_len;
      run_len = 1;
      lvl_q = {csn_o, sck_o};
    end else run_len++;
  end

  task automatic run_txn(input bit rd, input int len, input logic [7:0] cmd);
    int eff;
    logic [7:0] wexp [64];
    eff = (len > MAXL) ? MAXL : len;
    s_seed = 8'(n_tx * 13 + 5);
    s_base = 8'(n_tx * 7 + 1);
    n_tx++;
    rd_n = 0; wr_acc = 0;
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_rd_i = rd; req_len_i = 6'(len); req_cmd_i = cmd;
    wr_valid_i = rd || (eff == 0);  // offered but must be ignored
    wr_data_i = 8'hA5;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after accept", busy_o, 1);
    if (!rd) begin
      for (int k = 0; k < eff; k++) begin
        wexp[k] = 8'(int'(s_base) ^ (k * 11 + 3));
        wr_data_i = wexp[k];
        wr_valid_i = 1'b1;
        while (!wr_ready_o) @(negedge clk_i);
        @(negedge clk_i);
        wr_valid_i = 1'b0;
      end
    end
    while (!done_o) @(negedge clk_i);
    chk(status_o == s_seed, "R3 status", status_o, s_seed);
    chk(csn_o && !busy_o, "R9 csn/busy at done", {csn_o, busy_o}, 2);
    chk(s_nbytes == eff + 1, "R7 bytes in frame", s_nbytes, eff + 1);
    chk(s_bit == 0, "R7 whole bytes", s_bit, 0);
    chk(s_got[0] == cmd, "R2 command byte", s_got[0], cmd);
    if (eff == 0)
      chk(s_nbytes == 1 && rd_n == 0 && wr_acc == 0, "R6 zero length",
          s_nbytes * 256 + rd_n * 16 + wr_acc, 256);
    if (rd) begin
      chk(rd_n == eff, "R5 read strobes", rd_n, eff);
      chk(wr_acc == 0, "R5 write stream ignored", wr_acc, 0);
      for (int k = 0; k < eff; k++) begin
        chk(s_got[k+1] == 8'h00, "R5 filler", s_got[k+1], 0);
        chk(rd_got[k] == pat(s_base, k + 1), "R5 read data", rd_got[k], pat(s_base, k + 1));
      end
    end else begin
      chk(wr_acc == eff, "R4 write handshakes", wr_acc, eff);
      chk(rd_n == 0, "R4 no read strobes", rd_n, 0);
      for (int k = 0; k < eff; k++)
        chk(s_got[k+1] == wexp[k], "R4 write data", s_got[k+1], wexp[k]);
    end
    if (len > MAXL) chk(s_nbytes == MAXL + 1, "R10 length clamp", s_nbytes, MAXL + 1);
    wr_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk(csn_o == 1'b1 && sck_o == 1'b0, "R1 reset pins", {csn_o, sck_o}, 2);
    chk(busy_o == 1'b0 && req_ready_o == 1'b1, "R1 reset flags", {busy_o, req_ready_o}, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(csn_o && !busy_o && req_ready_o, "R1 idle after reset", {csn_o, busy_o, req_ready_o}, 5);
    for (int l = 0; l <= MAXL; l++) run_txn(1'b0, l, 8'(8'h20 | (l % 32)));
    for (int l = 0; l <= MAXL; l++) run_txn(1'b1, l, 8'(l % 32));
    run_txn(1'b1, 45, 8'h11);
    run_txn(1'b0, 40, 8'h31);
    run_txn(1'b0, 0, 8'hE1);
    repeat (2 * HALF) @(negedge clk_i);
    chk(min_run >= HALF, "R8 minimum phase", min_run, HALF);
    chk(busy_err == 0, "R9 busy through frame", busy_err, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule